// File: doc/BRIEF.md
# Chained Serial DAC Write Sequencer

This block sits on the controller side of a three-wire serial link to one or more multi-channel DACs. A local client hands it a command word holding one 18-bit frame for each device in the chain. The block serializes the whole word under a single active-low frame strobe (`sync_n`), MSB first, with a serial clock that idles low. It then raises the strobe, pulses `done` and returns to idle.

Each device frame carries a 2-bit operation, a 4-bit channel address and a 12-bit code. The operations are: 00 load, 01 step up, 10 step down, 11 keep (the device does nothing). Before every frame the sequencer waits until the devices report ready on `busy_n`. It also waits out a hold-off counted from the previous strobe rise. The hold-off is long after a frame that carried a step operation and short otherwise. The long value depends on whether one device or a chain is attached. After the strobe falls, it holds a setup interval before it starts the serial clock.

The controller is a five-state machine. IDLE accepts a request and moves to WAIT. WAIT moves to SETUP once `busy_n` is high and the hold-off has expired; the strobe falls on entry to SETUP. SETUP moves to SHIFT after `SETUP_CYC` cycles. SHIFT toggles the serial clock every `HALF_CYC` cycles and moves to CLOSE after the last falling clock edge. CLOSE moves back to IDLE after one more half period; the strobe rises and `done` pulses on that transition.

Top module: `sdac_wr_seq`

## Requirements
- R1: Slot 0 occupies bits [18·N−1 : 18·N−18] of `req_cmd` and is sent first. Every bit of the command word appears on `sdo`, MSB first. Within a slot, bits [17:16] are the operation, [15:12] the channel and [11:0] the code.
- R2: Exactly 18·`N_DEV` falling `sclk` edges occur in each period in which `sync_n` is low.
- R3: `sclk` is low whenever `sync_n` is high. While `sync_n` is low, `sdo` changes only in the cycle in which `sclk` rises, so it is stable across every falling edge.
- R4: The first rising `sclk` edge of a frame comes at least `SETUP_CYC` cycles after the falling edge of `sync_n`.
- R5: `sync_n` never falls in a cycle that follows a cycle in which `busy_n` was low.
- R6: A frame containing a step operation (01 or 10) is followed by at least `GAP_CHAIN` cycles (`N_DEV` > 1) or `GAP_SOLO` cycles (`N_DEV` = 1) between the rise of `sync_n` and its next fall.
- R7: A frame whose slots are only load or keep (00 or 11) is sent bit-exact. It imposes only `SETTLE_CYC` of hold-off, so a waiting request starts within a few cycles of `busy_n` going high.
- R8: `req_ready` is high only in IDLE, and one handshake yields exactly one frame. `done` is a single-cycle pulse in the cycle in which `sync_n` rises, and appears at no other time.
- R9: During and immediately after reset, `sync_n` is high, `sclk` is low, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command word offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_cmd | input | 18·N_DEV | Slot 0 in the top 18 bits |
| done | output | 1 | One-cycle pulse when the strobe rises |
| busy_n | input | 1 | Device ready (low while converting) |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |

## Verification
The bench holds `busy_n` low for a fixed time after every strobe rise while a request is already pending. A design that ignored the busy line would drop the strobe early. The bench places a load frame directly after a step frame: a sequencer that used the single-device gap, or no gap, would restart too soon. A keep-only frame is followed by a pending request, which catches a design that treated keep as a step and stalled. Bit order, chain length, data stability at the falling edge and the setup interval are measured on every frame. Mis-ordered slots, a missing or extra clock, or a clock started right at the strobe edge would all show up there.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int FRAME_W = 18;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_INC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_KEEP = 2'b11
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [3:0]  chan;
        logic [11:0] code;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_SHIFT,
        ST_CLOSE
    } seq_st_e;
endpackage

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], 1'b0};
    end

    assign msb = q[W-1];
endmodule

// File: rtl/sdac_holdoff.sv
module sdac_holdoff #(
    parameter int LONG  = 100,
    parameter int SHORT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic clear
);
    localparam int MAXV = (LONG > SHORT) ? LONG : SHORT;
    localparam int W    = $clog2(MAXV + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= long_sel ? W'(LONG) : W'(SHORT);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign clear = (cnt == '0);

    // R6
    hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !clear);
endmodule

// File: rtl/sdac_wr_seq.sv
module sdac_wr_seq
    import sdac_pkg::*;
#(
    parameter int N_DEV      = 2,
    parameter int HALF_CYC   = 2,
    parameter int SETUP_CYC  = 4,
    parameter int GAP_SOLO   = 50,
    parameter int GAP_CHAIN  = 100,
    parameter int SETTLE_CYC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [FRAME_W*N_DEV-1:0]   req_cmd,
    output logic                       done,
    input  logic                       busy_n,
    output logic                       sync_n,
    output logic                       sclk,
    output logic                       sdo
);
    localparam int TOTAL    = FRAME_W * N_DEV;
    localparam int BIT_W    = $clog2(TOTAL + 1);
    localparam int CNT_MAX  = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int GAP_STEP = (N_DEV > 1) ? GAP_CHAIN : GAP_SOLO;

    seq_st_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             sclk_q, sync_q, done_q, step_q;
    logic             accept, half_end, setup_end, last_fall;
    logic             hold_clear, hold_load, shift_en;
    logic [N_DEV-1:0] slot_step;

    // A slot is a step when its two operation bits differ (01 or 10).
    for (genvar g = 0; g < N_DEV; g++) begin : g_slot
        assign slot_step[g] = req_cmd[g*FRAME_W + FRAME_W - 1] ^ req_cmd[g*FRAME_W + FRAME_W - 2];
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign half_end  = (cnt_q == CNT_W'(HALF_CYC - 1));
    assign setup_end = (cnt_q == CNT_W'(SETUP_CYC - 1));
    assign last_fall = half_end && sclk_q && (bit_q == BIT_W'(TOTAL - 1));
    assign hold_load = (state_q == ST_CLOSE) && half_end;
    assign shift_en  = (state_q == ST_SHIFT) && half_end && !sclk_q && (bit_q != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)              state_d = ST_WAIT;
            ST_WAIT:  if (busy_n && hold_clear)   state_d = ST_SETUP;
            ST_SETUP: if (setup_end)              state_d = ST_SHIFT;
            ST_SHIFT: if (last_fall)              state_d = ST_CLOSE;
            ST_CLOSE: if (half_end)               state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            sync_q <= 1'b1;
            done_q <= 1'b0;
            step_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_d != state_q || state_q == ST_IDLE || state_q == ST_WAIT)
                cnt_q <= '0;
            else if (state_q == ST_SHIFT && half_end)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;

            unique case (state_q)
                ST_IDLE: if (accept) step_q <= |slot_step;
                ST_WAIT: if (state_d == ST_SETUP) begin
                    sync_q <= 1'b0;
                    bit_q  <= '0;
                end
                ST_SETUP: ;
                ST_SHIFT: if (half_end) begin
                    sclk_q <= !sclk_q;
                    if (sclk_q) bit_q <= bit_q + 1'b1;
                end
                ST_CLOSE: if (half_end) begin
                    sync_q <= 1'b1;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    sdac_shreg #(.W(TOTAL)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_cmd),
        .shift    (shift_en),
        .msb      (sdo)
    );

    sdac_holdoff #(.LONG(GAP_STEP), .SHORT(SETTLE_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .long_sel (step_q),
        .clear    (hold_clear)
    );

    assign sclk   = sclk_q;
    assign sync_n = sync_q;
    assign done   = done_q;

    // Checker-side counters
    logic             sclk_prev;
    logic [BIT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] lead_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            fall_cnt  <= '0;
            lead_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (sync_n)
                fall_cnt <= '0;
            else if (sclk_prev && !sclk)
                fall_cnt <= fall_cnt + 1'b1;
            if (sync_n)
                lead_cnt <= '0;
            else if (lead_cnt != CNT_W'(SETUP_CYC))
                lead_cnt <= lead_cnt + 1'b1;
        end
    end

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> !sclk);

    // R5
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && !busy_n) |=> sync_n);

    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> !req_ready);

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(sync_n));

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (fall_cnt == BIT_W'(TOTAL)));

    // R4
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && fall_cnt == '0) |-> (lead_cnt == CNT_W'(SETUP_CYC)));
endmodule

// File: tb/sdac_wr_seq_tb.sv
module sdac_wr_seq_tb;
    import sdac_pkg::*;

    localparam int N_DEV      = 2;
    localparam int HALF_CYC   = 2;
    localparam int SETUP_CYC  = 4;
    localparam int GAP_SOLO   = 50;
    localparam int GAP_CHAIN  = 100;
    localparam int SETTLE_CYC = 2;
    localparam int TOTAL      = FRAME_W * N_DEV;
    localparam int GAP_EXP    = (N_DEV > 1) ? GAP_CHAIN : GAP_SOLO;
    localparam int BUSY_LEN   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [TOTAL-1:0] req_cmd = '0;
    logic done;
    logic busy_n = 1'b1;
    logic sync_n, sclk, sdo;

    always #2 clk = ~clk;

    sdac_wr_seq #(
        .N_DEV(N_DEV), .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC),
        .GAP_SOLO(GAP_SOLO), .GAP_CHAIN(GAP_CHAIN), .SETTLE_CYC(SETTLE_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .done(done), .busy_n(busy_n),
        .sync_n(sync_n), .sclk(sclk), .sdo(sdo)
    );

    int vec = 0;
    int err = 0;
    logic [TOTAL-1:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        vec++;
        if (!ok) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [FRAME_W-1:0] mk(input op_e op, input logic [3:0] ch, input logic [11:0] code);
        return {op, ch, code};
    endfunction

    task automatic send(input logic [TOTAL-1:0] c);
        exp_q.push_back(c);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and busy model
    int cyc = 0, fall_t = 0, rise_t = 0, nb = 0, busy_left = 0;
    logic p_sync = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_busy = 1'b1;
    logic [TOTAL-1:0] cap = '0;
    bit first_rise = 1'b0, last_step = 1'b0, last_keep = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) busy_n = 1'b1;
        end
        if (rst_n) begin
            if (sync_n && sclk) chk(0, "R3 sclk high while idle", sclk, 0);
            if (p_sync && !sync_n) begin
                chk(p_busy, "R5 start while busy", p_busy, 1);
                if (last_step) chk(cyc - rise_t >= GAP_EXP, "R6 step gap", cyc - rise_t, GAP_EXP);
                if (last_keep) chk(cyc - rise_t <= BUSY_LEN + SETTLE_CYC + 6, "R7 settle too long",
                                   cyc - rise_t, BUSY_LEN + SETTLE_CYC + 6);
                fall_t = cyc; nb = 0; cap = '0; first_rise = 1'b1;
            end
            if (!sync_n && !p_sync && (sdo != p_sdo) && !(sclk && !p_sclk))
                chk(0, "R3 sdo moved off rising edge", sdo, p_sdo);
            if (!sync_n && sclk && !p_sclk && first_rise) begin
                chk(cyc - fall_t >= SETUP_CYC, "R4 setup", cyc - fall_t, SETUP_CYC);
                first_rise = 1'b0;
            end
            if (p_sclk && !sclk) begin
                cap = {cap[TOTAL-2:0], sdo};
                nb++;
            end
            if (!p_sync && sync_n) begin
                logic [TOTAL-1:0] e;
                chk(done, "R8 done at strobe rise", done, 1);
                chk(nb == TOTAL, "R2 clock count", nb, TOTAL);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected frame", cap, 0);
                    e = '0;
                end else begin
                    e = exp_q.pop_front();
                    chk(cap == e, "R1 frame bits", cap, e);
                end
                last_step = 1'b0; last_keep = 1'b1;
                for (int s = 0; s < N_DEV; s++) begin
                    logic [1:0] op;
                    op = e[s*FRAME_W + 16 +: 2];
                    if (op == 2'b01 || op == 2'b10) last_step = 1'b1;
                    if (op != 2'b11) last_keep = 1'b0;
                end
                rise_t = cyc;
                busy_n = 1'b0;
                busy_left = BUSY_LEN;
            end else if (done) begin
                chk(0, "R8 stray done", done, 0);
            end
        end
        p_sync = sync_n; p_sclk = sclk; p_sdo = sdo; p_busy = busy_n;
    end

    bit finished = 1'b0;

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            err++; vec++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(sync_n == 1'b1 && sclk == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            "R9 in reset", {sync_n, sclk, done, req_ready}, 4'b1001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_n == 1'b1 && sclk == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            "R9 after reset", {sync_n, sclk, done, req_ready}, 4'b1001);

        // R1 mixed load patterns
        send({mk(OP_LOAD, 4'd3, 12'hA5C), mk(OP_LOAD, 4'd15, 12'h001)});
        // R6 step frame followed straight away by a load frame
        send({mk(OP_INC, 4'd1, 12'h07F), mk(OP_KEEP, 4'd0, 12'h000)});
        send({mk(OP_LOAD, 4'd0, 12'hFFF), mk(OP_LOAD, 4'd10, 12'h800)});
        // R7 keep-only frame, then a pending request
        send({mk(OP_KEEP, 4'd9, 12'h555), mk(OP_KEEP, 4'd6, 12'hAAA)});
        send({mk(OP_LOAD, 4'd5, 12'h000), mk(OP_LOAD, 4'd12, 12'h3C3)});
        // R6 decrement in the second slot
        send({mk(OP_KEEP, 4'd2, 12'h000), mk(OP_DEC, 4'd14, 12'h00A)});
        send({mk(OP_LOAD, 4'd7, 12'h123), mk(OP_INC, 4'd8, 12'h001)});
        send({mk(OP_LOAD, 4'd4, 12'hFED), mk(OP_LOAD, 4'd11, 12'hBA9)});

        while (exp_q.size() != 0 || !sync_n) @(negedge clk);
        repeat (BUSY_LEN + 10) @(negedge clk);
        // R8 idle and ready once all frames are out
        chk(req_ready == 1'b1 && sync_n == 1'b1, "R8 idle at end", {req_ready, sync_n}, 2'b11);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule